// File: doc/BRIEF.md
# Batched UART Echo Controller

This controller sits on the parallel side of a UART core. It does not handle serial bits. It gathers a fixed number of received bytes into a small buffer. When the batch is full, it writes the bytes back to the UART transmitter in the order they arrived. It then clears its count and starts collecting again.

The UART signals that a byte is ready with a data-available flag. The controller then takes the byte and answers with a one-clock read acknowledge. During the send phase, it waits for the transmitter's buffer-empty flag before each one-clock write strobe. An LED byte shows the most recent received byte with its bits in reverse order. A count output shows how many bytes of the current batch are held. The receiver's error flags (parity, framing, overrun) are accepted and have no effect.

Top module: `echo_batcher`

## Requirements
- R1: Reset is synchronous and active low (`rst_n`). After a rising edge with `rst_n` low, the controller waits for a byte, `count` is 0, `rd_ack` and `wr_stb` are low, and `led` and `tx_byte` are 0.
- R2: While the controller is waiting for a byte, `rd_ack` and `wr_stb` are both low. The two strobes are never high together.
- R3: On the edge where `rx_avail` is high while the controller waits, the byte on `rx_byte` is stored. The strobe comes after the byte is stored: `rd_ack` goes high in the following cycle.
- R4: `rd_ack` is high for exactly one cycle per accepted byte. `rx_avail` is not sampled in that cycle, and the controller then returns to waiting.
- R5: `count` increments by exactly one on the edge that stores a byte. It is 0 after reset and never exceeds BATCH (default 4).
- R6: `led` holds the most recently stored byte with its bits in reverse order: `led[7]` is data bit 0 and `led[0]` is data bit 7. It updates on the edge that stores the byte.
- R7: The acknowledge cycle for the BATCH-th byte leads into the send phase. Each write waits until `tx_empty` is high on a rising edge. The next cycle, `wr_stb` is high for one cycle and `tx_byte` holds the byte being sent.
- R8: Exactly BATCH writes follow each full batch, and they carry the bytes in the order they were received.
- R9: On the edge that ends the last write strobe, `count` returns to 0 and the controller resumes waiting for bytes.
- R10: During the send phase, a high `rx_avail` is not acknowledged. That byte is accepted only after collection resumes.
- R11: The error flags `rx_err` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Byte from the UART receiver |
| rx_avail | input | 1 | Receiver holds an unread byte |
| tx_empty | input | 1 | Transmitter can take a byte |
| rx_err | input | 3 | Parity, framing and overrun flags (ignored) |
| tx_byte | output | 8 | Byte presented to the transmitter |
| rd_ack | output | 1 | One-cycle read acknowledge to the receiver |
| wr_stb | output | 1 | One-cycle write strobe to the transmitter |
| led | output | 8 | Last received byte, bit-reversed |
| count | output | 3 | Bytes held in the current batch |

## Verification
A wrong buffer index or read pointer shows up as a byte out of order or duplicated on `tx_byte` at the first write of that batch. This is at most BATCH writes after the bad store. A counter that skips or sticks shows on `count` in the acknowledge cycle. It also shows as a send phase that starts one byte early or late, which moves `wr_stb` by whole byte periods. Strobe errors, such as a second acknowledge, a write without `tx_empty`, or an acknowledge during the send phase, show up within one cycle. The bench compares every output against a behavioural model on every clock, so these faults are caught in the cycle where they appear.

// File: rtl/echo_pkg.sv
// Package: shared types and helpers for the batched echo controller.
// Assumes: nothing beyond IEEE 1800-2017.
package echo_pkg;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,   // collecting, waiting for rx_avail
        ST_ACK     = 2'd1,   // one-cycle read acknowledge
        ST_TXWAIT  = 2'd2,   // sending, waiting for tx_empty
        ST_TXPULSE = 2'd3    // one-cycle write strobe
    } echo_state_e;

endpackage

// File: rtl/echo_ctrl_fsm.sv
// Module: sequencing FSM of the batched echo controller.
// Assumes: batch_full and last_slot come from the byte store and are
// registered-state based; rx_avail and tx_empty are synchronous to clk.
module echo_ctrl_fsm
    import echo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_avail,
    input  logic        tx_empty,
    input  logic        batch_full,
    input  logic        last_slot,
    output echo_state_e st,
    output logic        capture,
    output logic        load_tx,
    output logic        advance
);

    echo_state_e st_nx;

    // Next-state selection for the collect / acknowledge / send loop.
    always_comb begin
        st_nx = st;
        case (st)
            ST_WAIT:    if (rx_avail) st_nx = ST_ACK;
            ST_ACK:     st_nx = batch_full ? ST_TXWAIT : ST_WAIT;
            ST_TXWAIT:  if (tx_empty) st_nx = ST_TXPULSE;
            ST_TXPULSE: st_nx = last_slot ? ST_WAIT : ST_TXWAIT;
            default:    st_nx = ST_WAIT;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_WAIT;
        else        st <= st_nx;
    end

    // Event pulses consumed by the byte store and LED view.
    assign capture = (st == ST_WAIT) && rx_avail;
    assign load_tx = (st == ST_TXWAIT) && tx_empty;
    assign advance = (st == ST_TXPULSE);

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK) |=> (st != ST_ACK));

    // R7
    write_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TXPULSE) |-> $past(tx_empty));

    // R10
    no_ack_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TXWAIT && rx_avail && !tx_empty) |=> (st == ST_TXWAIT));

endmodule

// File: rtl/echo_byte_store.sv
// Module: batch buffer, received-byte counter and transmit register.
// Assumes: capture never arrives when the batch is full (the FSM leaves
// collection first); BATCH is at least 2.
module echo_byte_store #(
    parameter int DW    = 8,
    parameter int BATCH = 4,
    localparam int CW   = $clog2(BATCH + 1),
    localparam int IW   = $clog2(BATCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          load_tx,
    input  logic          advance,
    input  logic [DW-1:0] rx_byte,
    output logic [CW-1:0] count,
    output logic [DW-1:0] tx_byte,
    output logic          batch_full,
    output logic          last_slot
);

    logic [DW-1:0] mem [BATCH];
    logic [IW-1:0] rd_idx;

    assign batch_full = (count == CW'(BATCH));
    assign last_slot  = (rd_idx == IW'(BATCH - 1));

    // Store incoming bytes at the slot selected by the running count.
    always_ff @(posedge clk) begin
        if (capture) mem[count[IW-1:0]] <= rx_byte;
    end

    // Registered byte counter: +1 per stored byte, clear after last write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (capture)               count <= count + CW'(1);
        else if (advance && last_slot)  count <= '0;
    end

    // Read pointer walks the buffer in arrival order during sending.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_idx <= '0;
        else if (advance) rd_idx <= last_slot ? '0 : rd_idx + IW'(1);
    end

    // Transmit register, loaded one cycle before the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_byte <= '0;
        else if (load_tx)  tx_byte <= mem[rd_idx];
    end

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(BATCH));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> count == $past(count) + CW'(1));

    // R9
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && last_slot) |=> count == '0);

endmodule

// File: rtl/echo_led_view.sv
// Module: LED display register showing the last stored byte bit-reversed.
// Assumes: capture marks the edge on which rx_byte is accepted.
module echo_led_view #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] rx_byte,
    output logic [DW-1:0] led
);

    logic [DW-1:0] flipped;

    // Reverse the bit order of the incoming byte.
    for (genvar i = 0; i < DW; i++) begin : g_flip
        assign flipped[i] = rx_byte[DW-1-i];
    end

    // Display register updated on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       led <= '0;
        else if (capture) led <= flipped;
    end

    // R6
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(led));

endmodule

// File: rtl/echo_batcher.sv
// Module: top of the batched UART echo controller. Collects BATCH bytes
// from a UART's parallel receive side, then writes them back in order.
// Assumes: rx_avail stays high until rd_ack is seen; tx_empty is high
// whenever the transmitter can take a byte; rx_err is informational only.
module echo_batcher #(
    parameter int DW    = 8,
    parameter int BATCH = 4,
    parameter int EW    = 3,
    localparam int CW   = $clog2(BATCH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_avail,
    input  logic          tx_empty,
    input  logic [EW-1:0] rx_err,
    output logic [DW-1:0] tx_byte,
    output logic          rd_ack,
    output logic          wr_stb,
    output logic [DW-1:0] led,
    output logic [CW-1:0] count
);
    import echo_pkg::*;

    echo_state_e st;
    logic        capture;
    logic        load_tx;
    logic        advance;
    logic        batch_full;
    logic        last_slot;
    logic        unused_err;

    // Error flags are accepted but deliberately have no effect.
    assign unused_err = ^rx_err;

    echo_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_avail   (rx_avail),
        .tx_empty   (tx_empty),
        .batch_full (batch_full),
        .last_slot  (last_slot),
        .st         (st),
        .capture    (capture),
        .load_tx    (load_tx),
        .advance    (advance)
    );

    echo_byte_store #(.DW(DW), .BATCH(BATCH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .load_tx    (load_tx),
        .advance    (advance),
        .rx_byte    (rx_byte),
        .count      (count),
        .tx_byte    (tx_byte),
        .batch_full (batch_full),
        .last_slot  (last_slot)
    );

    echo_led_view #(.DW(DW)) u_led (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .rx_byte (rx_byte),
        .led     (led)
    );

    // Strobes decoded from the registered state.
    assign rd_ack = (st == ST_ACK);
    assign wr_stb = (st == ST_TXPULSE);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ack && wr_stb));

    // R3
    ack_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> $past(rx_avail) && !$past(rd_ack) && !$past(wr_stb));

endmodule

// File: tb/sim_echo_batcher.sv
module sim_echo_batcher;
    localparam int B = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_avail = 1'b0;
    logic       tx_empty = 1'b1;
    logic [2:0] rx_err = 3'b000;
    logic [7:0] tx_byte;
    logic       rd_ack;
    logic       wr_stb;
    logic [7:0] led;
    logic [2:0] count;

    int checks = 0;
    int fails = 0;
    int tx_lat = 3;
    int busy = 0;

    always #5 clk = ~clk;

    echo_batcher u0 (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_avail(rx_avail),
        .tx_empty(tx_empty), .rx_err(rx_err), .tx_byte(tx_byte),
        .rd_ack(rd_ack), .wr_stb(wr_stb), .led(led), .count(count)
    );

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: phase 0 wait, 1 ack, 2 send-wait, 3 write pulse.
    int         m_ph = 0;
    int         m_cnt = 0;
    logic [7:0] m_led = 0;
    logic [7:0] m_tx = 0;
    logic [7:0] m_q[$];
    logic [7:0] sent_log[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_led = 0; m_tx = 0; m_q.delete();
        end else begin
            case (m_ph)
                0: if (rx_avail) begin
                       m_q.push_back(rx_byte); m_led = rev8(rx_byte);
                       m_cnt++; m_ph = 1;
                   end
                1: m_ph = (m_cnt == B) ? 2 : 0;
                2: if (tx_empty) begin m_tx = m_q.pop_front(); m_ph = 3; end
                default: if (m_q.size() == 0) begin m_cnt = 0; m_ph = 0; end
                         else m_ph = 2;
            endcase
        end
    end

    // Compare every output on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rd_ack == (m_ph == 1), "R2 R4 rd_ack", rd_ack, m_ph == 1);
            chk(wr_stb == (m_ph == 3), "R7 wr_stb", wr_stb, m_ph == 3);
            chk(count == m_cnt[2:0], "R5 R9 count", count, m_cnt);
            chk(led == m_led, "R6 R11 led", led, m_led);
            chk(tx_byte == m_tx, "R8 tx_byte", tx_byte, m_tx);
            if (m_ph == 3 && rx_avail)
                chk(rd_ack == 1'b0, "R10 pending byte held", rd_ack, 0);
            if (wr_stb) sent_log.push_back(tx_byte);
        end
    end

    // Transmitter partner: goes busy for tx_lat cycles after each write.
    always @(posedge clk) begin
        #1;
        if (wr_stb && tx_lat > 0) begin tx_empty = 1'b0; busy = tx_lat; end
        else if (busy > 0) begin busy--; if (busy == 0) tx_empty = 1'b1; end
    end

    task automatic push(input logic [7:0] b);
        @(posedge clk); #1;
        rx_byte = b; rx_avail = 1'b1; rx_err = 3'($urandom);
        do begin @(posedge clk); #1; rx_err = 3'($urandom); end while (!rd_ack);
        rx_avail = 1'b0;
        chk(led == rev8(b), "R3 R6 R11 stored byte", led, rev8(b));
    endtask

    task automatic wait_sent(input int n);
        while (sent_log.size() < n) @(posedge clk);
    endtask

    task automatic check_order(input logic [7:0] e [4], input int base);
        for (int i = 0; i < B; i++)
            chk(sent_log[base+i] == e[i], "R8 echo order", sent_log[base+i], e[i]);
    endtask

    initial begin
        logic [7:0] e1 [4] = '{8'h01, 8'h80, 8'hA5, 8'h3C};
        logic [7:0] e2 [4] = '{8'hFF, 8'h00, 8'h5A, 8'hC3};
        logic [7:0] e3 [4] = '{8'h12, 8'h34, 8'h56, 8'h78};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(count == 0 && !rd_ack && !wr_stb, "R1 reset strobes/count", count, 0);
        chk(led == 0 && tx_byte == 0, "R1 reset led/tx", led, 0);
        #1 rst_n = 1'b1;

        foreach (e1[i]) push(e1[i]);
        wait_sent(4);
        check_order(e1, 0);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(count == 0, "R9 count cleared", count, 0);

        tx_lat = 0;
        for (int i = 0; i < 3; i++) push(e2[i]);
        fork
            push(e2[3]);
        join
        fork
            push(8'h99);     // arrives in send phase, held pending (R10)
        join_none
        wait_sent(8);
        check_order(e2, 4);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(count == 1, "R10 pending byte taken after send", count, 1);
        chk(led == rev8(8'h99), "R10 pending byte value", led, rev8(8'h99));

        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(count == 0 && led == 0, "R1 mid-batch reset", count, 0);

        tx_lat = 2;
        sent_log.delete();
        foreach (e3[i]) push(e3[i]);
        wait_sent(4);
        check_order(e3, 0);
        repeat (8) @(posedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule